// File: doc/BRIEF.md
# Iterative Euclidean GCD Coprocessor

This block computes the greatest common divisor of two unsigned operands of a configurable width, from 32 to 1024 bits. It runs Euclid's remainder method. Each remainder is formed by subtracting the divisor repeatedly from the dividend until the dividend is smaller than the divisor. The two operand registers are then exchanged, so the remainder becomes the new divisor. The loop ends when the divisor register holds zero. The value left in the dividend register is then copied into a dedicated result register.

A host starts a computation by raising `en`. The block captures both operand inputs once, iterates without further input, and then raises `ack` together with a valid `result`. `ack` stays high for as long as `en` is held. Dropping `en` returns the block to idle, and the next rising of `en` starts a fresh computation. Each subtraction costs one cycle, and each exchange costs two cycles: one decision cycle and one swap cycle. The latency therefore follows directly from the quotient sequence of the operand pair.

Top module: `euclid_gcd_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `ack` and `result` to zero after that edge.
- R2: For any two operands with a non-zero second operand, `result` equals their greatest common divisor when `ack` rises. Equal operands yield that same value, and co-prime operands yield 1.
- R3: If the second operand is zero, the result is the first operand unchanged. This covers the first operand being all ones, and both operands zero gives 0. If only the first operand is zero, the result is the second operand.
- R4: A first operand smaller than the second gives the same result as the exchanged pair.
- R5: `ack` stays high on every cycle that `en` remains high after completion, and no new computation starts during that time.
- R6: One cycle after `en` is sampled low while `ack` is high, `ack` is low and the block is idle.
- R7: The operand inputs are captured only on the second clock edge after `en` is first sampled high in idle. Any later change on `op_a` or `op_b` has no effect on the running computation.
- R8: `result` changes only on the edge at which `ack` rises, and it holds its value while idle and while `ack` is high.
- R9: Counted in clock edges from the edge that first samples `en` high, `ack` rises after S + 2·X + 3 edges. Here S is the total number of single subtractions and X is the number of operand exchanges the remainder loop performs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Start request; held high until acknowledged, dropped to release |
| op_a | input | WIDTH | First operand (dividend at start) |
| op_b | input | WIDTH | Second operand (divisor at start) |
| result | output | WIDTH | Greatest common divisor, valid while `ack` is high |
| ack | output | 1 | Completion flag |

## Verification
The bench builds the block with WIDTH set to 64. At that width, all-ones operands and a pair of consecutive Fibonacci numbers just below 2^64 can be tested. The Fibonacci pair is the longest exchange chain the width allows, and it exercises the full-width subtractor and comparator. Random operand pairs are built backwards from a random divisor with small quotients. This keeps every run short while still covering deep remainder chains, co-prime pairs and reversed operand order. The exact latency formula is checked against a cycle count for every pair.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_REDUCE,
        ST_SWAP,
        ST_DONE
    } gcd_state_t;

    typedef struct packed {
        logic load;     // capture operand inputs
        logic sub;      // dividend <= dividend - divisor
        logic swap;     // exchange dividend and divisor
        logic capture;  // copy dividend into result register
    } gcd_ctl_t;

endpackage

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
    import gcd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     b_zero,
    input  logic     a_lt_b,
    output gcd_ctl_t ctl,
    output logic     ack
);

    gcd_state_t state_q;
    gcd_state_t state_d;

    always_comb begin
        state_d = state_q;
        ctl     = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (en) state_d = ST_LOAD;
            end
            ST_LOAD: begin
                ctl.load = 1'b1;
                state_d  = ST_REDUCE;
            end
            ST_REDUCE: begin
                if (b_zero) begin
                    ctl.capture = 1'b1;
                    state_d     = ST_DONE;
                end else if (!a_lt_b) begin
                    ctl.sub = 1'b1;
                end else begin
                    state_d = ST_SWAP;
                end
            end
            ST_SWAP: begin
                ctl.swap = 1'b1;
                state_d  = ST_REDUCE;
            end
            ST_DONE: begin
                if (!en) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign ack = (state_q == ST_DONE);

endmodule

// File: rtl/gcd_compare.sv
module gcd_compare #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_val,
    input  logic [WIDTH-1:0] b_val,
    output logic             b_zero,
    output logic             a_lt_b
);

    assign b_zero = (b_val == '0);
    assign a_lt_b = (a_val < b_val);

endmodule

// File: rtl/gcd_operands.sv
module gcd_operands
    import gcd_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  gcd_ctl_t         ctl,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    output logic [WIDTH-1:0] a_q,
    output logic [WIDTH-1:0] b_q
);

    logic [WIDTH-1:0] diff;

    // Subtraction unit: one divisor removed from the dividend per cycle
    assign diff = a_q - b_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
        end else if (ctl.load) begin
            a_q <= in_a;
            b_q <= in_b;
        end else if (ctl.sub) begin
            a_q <= diff;
        end else if (ctl.swap) begin
            a_q <= b_q;
            b_q <= a_q;
        end
    end

endmodule

// File: rtl/gcd_result.sv
module gcd_result #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [WIDTH-1:0] value,
    output logic [WIDTH-1:0] result
);

    always_ff @(posedge clk) begin
        if (rst)          result <= '0;
        else if (capture) result <= value;
    end

endmodule

// File: rtl/euclid_gcd_unit.sv
module euclid_gcd_unit
    import gcd_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] result,
    output logic             ack
);

    gcd_ctl_t         ctl;
    logic [WIDTH-1:0] a_q;
    logic [WIDTH-1:0] b_q;
    logic             b_zero;
    logic             a_lt_b;

    gcd_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .b_zero (b_zero),
        .a_lt_b (a_lt_b),
        .ctl    (ctl),
        .ack    (ack)
    );

    gcd_operands #(.WIDTH(WIDTH)) u_ops (
        .clk  (clk),
        .rst  (rst),
        .ctl  (ctl),
        .in_a (op_a),
        .in_b (op_b),
        .a_q  (a_q),
        .b_q  (b_q)
    );

    gcd_compare #(.WIDTH(WIDTH)) u_cmp (
        .a_val  (a_q),
        .b_val  (b_q),
        .b_zero (b_zero),
        .a_lt_b (a_lt_b)
    );

    gcd_result #(.WIDTH(WIDTH)) u_res (
        .clk     (clk),
        .rst     (rst),
        .capture (ctl.capture),
        .value   (a_q),
        .result  (result)
    );

endmodule

// File: rtl/gcd_checker.sv
module gcd_checker #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             ack,
    input logic             swap_now,
    input logic [WIDTH-1:0] result,
    input logic [WIDTH-1:0] a_q,
    input logic [WIDTH-1:0] b_q
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!ack && result == '0));

    // R2: after an exchange the new divisor is strictly below the dividend
    a_r2_swap_orders: assert property (@(posedge clk) disable iff (rst)
        swap_now |=> (b_q < a_q));

    a_r5_ack_holds: assert property (@(posedge clk) disable iff (rst)
        (ack && en) |=> ack);

    a_r6_ack_release: assert property (@(posedge clk) disable iff (rst)
        (ack && !en) |=> !ack);

    a_r8_result_only_on_done: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> $rose(ack));

endmodule

bind euclid_gcd_unit gcd_checker #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .ack      (ack),
    .swap_now (ctl.swap),
    .result   (result),
    .a_q      (a_q),
    .b_q      (b_q)
);

// File: tb/test_euclid_gcd_unit.sv
module test_euclid_gcd_unit;

    localparam int W       = 64;
    localparam int TIMEOUT = 20000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en  = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [W-1:0] result;
    logic         ack;

    int              checks = 0;
    int              errors = 0;
    longint unsigned cyc    = 0;

    typedef struct {
        logic [W-1:0]    exp;
        longint unsigned lat;
        longint unsigned start;
        string           tag;
    } item_t;

    item_t sb[$];

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    euclid_gcd_unit #(.WIDTH(W)) i_euclid_gcd_unit (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .op_a   (op_a),
        .op_b   (op_b),
        .result (result),
        .ack    (ack)
    );

    function automatic logic [W-1:0] ref_gcd(logic [W-1:0] a, logic [W-1:0] b);
        logic [W-1:0] t;
        while (b != 0) begin
            t = a % b;
            a = b;
            b = t;
        end
        return a;
    endfunction

    function automatic longint unsigned ref_latency(logic [W-1:0] a, logic [W-1:0] b);
        longint unsigned s = 0;
        longint unsigned x = 0;
        logic [W-1:0]    t;
        while (b != 0) begin
            while (a >= b) begin
                a = a - b;
                s++;
            end
            t = a;
            a = b;
            b = t;
            x++;
        end
        return s + 2 * x + 3;
    endfunction

    task automatic check(input bit ok, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Monitor: pops expected items when ack rises
    bit ack_seen = 1'b0;
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && ack && !ack_seen) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2 unexpected ack", W'(ack), '0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check(result == it.exp, {it.tag, " R7 result"}, result, it.exp);
                    check((cyc - it.start) == it.lat, {it.tag, " R9 latency"},
                          W'(cyc - it.start), W'(it.lat));
                end
            end
            ack_seen = ack;
        end
    end

    // Driver: one full handshake per pair
    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
        item_t        it;
        int           n;
        logic [W-1:0] held;
        @(negedge clk);
        op_a = a;
        op_b = b;
        en   = 1'b1;
        it.exp   = ref_gcd(a, b);
        it.lat   = ref_latency(a, b);
        it.start = cyc;
        it.tag   = tag;
        sb.push_back(it);
        @(negedge clk);
        @(negedge clk);
        op_a = ~a;                       // R7: disturb inputs after capture
        op_b = b ^ 64'h5a5a_0f0f_3c3c_9696;
        n = 0;
        while (!ack && n < TIMEOUT) begin
            @(negedge clk);
            n++;
        end
        if (!ack) begin
            check(1'b0, {tag, " R2 timeout"}, '0, it.exp);
            return;
        end
        held = result;
        repeat (3) @(negedge clk);
        check(ack == 1'b1, "R5 ack held while en high", W'(ack), 1);
        check(result == held, "R8 result stable while ack", result, held);
        en = 1'b0;
        @(negedge clk);
        check(ack == 1'b0, "R6 ack released", W'(ack), 0);
        op_a = a + 1;
        op_b = b + 3;
        repeat (2) @(negedge clk);
        check(result == held, "R8 result stable in idle", result, held);
        check(ack == 1'b0, "R6 stays idle without en", W'(ack), 0);
    endtask

    task automatic gen_pair(output logic [W-1:0] a, output logic [W-1:0] b, input bit coprime);
        logic [W-1:0] x;
        logic [W-1:0] y;
        logic [W-1:0] t;
        int           depth;
        x = '0;
        y = coprime ? W'(1) : W'($urandom_range(1, 1 << 20));
        depth = $urandom_range(1, 8);
        for (int i = 0; i < depth; i++) begin
            t = y * W'($urandom_range(1, 3)) + x;
            x = y;
            y = t;
        end
        a = y;
        b = x;
    endtask

    initial begin
        repeat (200000 - 10000) @(posedge clk);
        check(1'b0, "watchdog expired", '0, '0);
        finish_run();
    end

    initial begin
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] f0;
        logic [W-1:0] f1;
        logic [W:0]   nx;

        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(ack == 1'b0, "R1 ack after reset", W'(ack), 0);
        check(result == '0, "R1 result after reset", result, '0);
        rst = 1'b0;
        @(negedge clk);

        run(64'd123456789, 64'd0, "R3 b zero");
        run({W{1'b1}}, 64'd0, "R3 all ones b zero");
        run(64'd0, 64'd0, "R3 both zero");
        run(64'd0, 64'd987654, "R3 a zero");
        run(64'd6, 64'd4, "R2 small");
        run(64'd48, 64'd180, "R4 small reversed");
        run(64'hdead_beef_1234, 64'hdead_beef_1234, "R2 equal");
        run({W{1'b1}}, {W{1'b1}}, "R2 equal all ones");

        f0 = 1;
        f1 = 1;
        for (int i = 0; i < 200; i++) begin
            nx = {1'b0, f0} + {1'b0, f1};
            if (nx[W]) break;
            f0 = f1;
            f1 = nx[W-1:0];
        end
        run(f1, f0, "R2 fibonacci coprime");
        run(f0, f1, "R4 fibonacci reversed");

        for (int i = 0; i < 30; i++) begin
            gen_pair(a, b, 1'b0);
            run(a, b, "R2 random");
        end
        for (int i = 0; i < 10; i++) begin
            gen_pair(a, b, 1'b1);
            run(a, b, "R2 coprime");
        end
        for (int i = 0; i < 10; i++) begin
            gen_pair(a, b, 1'b0);
            run(b, a, "R4 reversed");
        end

        repeat (2) @(negedge clk);
        check(sb.size() == 0, "R2 scoreboard drained", W'(sb.size()), 0);
        finish_run();
    end

endmodule